// File: doc/BRIEF.md
# Token-Based Pipeline Occupancy Throttle

This block caps how many instruction packets may be in flight in a pipeline. It keeps a pool of tokens, and each fetched packet must take one. A fetch request is granted in the same cycle only while the pool holds at least one free token. The token comes back when the packet retires. A pipeline flush can return the tokens of every discarded packet at once, through a count input.

A writable limit sets how many tokens circulate. Raising the limit takes effect at once. Lowering it first takes idle tokens out of the free pool. Any shortfall is then swallowed from later returns until the tokens in circulation match the new limit. When the limit is at or below a programmable threshold, a low-speculation flag rises and the branch predictor enable falls.

Top module: `tok_throttle`

## Requirements
- R1: `fetch_gnt` is high in a cycle exactly when `fetch_req` is high and `tok_free` is non-zero. Each grant moves one token from free to in-flight at the next clock edge.
- R2: A retire count returns that many tokens. They go to the free pool at the next edge when no removal is pending.
- R3: A flush count returns that many tokens in one cycle. Retire and flush counts in the same cycle add together.
- R4: A grant and returns in the same cycle are all honoured: in-flight becomes old + grant - returns.
- R5: When the limit is at least the pipeline depth S, and each packet retires S-1 cycles after its grant, a continuously requesting fetch never stalls.
- R6: A limit write below the current limit first withdraws idle free tokens. The rest becomes pending removal, and returning tokens are swallowed until pending reaches zero.
- R7: A limit write above the current limit first cancels pending removals. The remainder is added to the free pool at the next edge.
- R8: A written limit above MAX_TOKENS is taken as MAX_TOKENS. `tok_limit` reads back the applied value.
- R9: `low_spec` is high exactly when `tok_limit` <= `lowspec_thr`, and `pred_en` is its inverse.
- R10: At every cycle, `tok_free` + `tok_inflight` = `tok_limit` + `tok_pending`, and `tok_pending` <= `tok_inflight`.
- R11: After reset, `tok_limit` = `tok_free` = RESET_LIMIT, `tok_inflight` = `tok_pending` = 0, and `fetch_gnt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_req | input | 1 | Fetch wants to issue one packet |
| fetch_gnt | output | 1 | Packet granted a token this cycle |
| retire_cnt | input | CW | Tokens returned by retiring packets this cycle |
| flush_cnt | input | CW | Tokens returned by flushed packets this cycle |
| limit_wr | input | 1 | Write strobe for the token limit |
| limit_wdata | input | CW | New token limit |
| lowspec_thr | input | CW | Limit threshold for low-speculation mode |
| tok_free | output | CW | Tokens idle in the pool |
| tok_inflight | output | CW | Tokens held by packets in the pipeline |
| tok_pending | output | CW | Tokens still to be swallowed from returns |
| tok_limit | output | CW | Applied token limit |
| low_spec | output | 1 | Limit at or below threshold |
| pred_en | output | 1 | Branch predictor enable |

## Verification
The assertions assume that the pipeline never returns more tokens in one cycle than it holds. That is, `retire_cnt` + `flush_cnt` never exceeds `tok_inflight` at the start of that cycle. They also assume that no return is sent for a packet granted in the same cycle. The bench keeps within this because it draws every return count from its own tally of tokens in flight. In the depth test it retires a packet only from its record of earlier grants. Limit writes and thresholds are swept freely, including values above MAX_TOKENS.

// File: rtl/tok_pkg.sv
package tok_pkg;
  typedef enum logic [1:0] {
    LIM_KEEP  = 2'd0,
    LIM_RAISE = 2'd1,
    LIM_LOWER = 2'd2
  } lim_act_e;

  localparam int RST_SYNC_STAGES = 2;
endpackage

// File: rtl/tok_grant.sv
module tok_grant #(
  parameter int CW = 4
) (
  input  logic          run,
  input  logic          req,
  input  logic [CW-1:0] free_q,
  output logic          gnt
);
  always_comb begin
    gnt = run & req & (free_q != '0);
  end
endmodule

// File: rtl/tok_return.sv
module tok_return #(
  parameter int CW = 4,
  parameter int SW = CW + 1
) (
  input  logic [CW-1:0] retire_cnt,
  input  logic [CW-1:0] flush_cnt,
  input  logic [CW-1:0] pend_q,
  output logic [SW-1:0] back,
  output logic [CW-1:0] swallow
);
  always_comb begin
    back    = SW'(retire_cnt) + SW'(flush_cnt);
    swallow = (back < SW'(pend_q)) ? CW'(back) : pend_q;
  end
endmodule

// File: rtl/tok_limit.sv
module tok_limit
  import tok_pkg::*;
#(
  parameter int MAX_TOKENS = 8,
  parameter int CW = 4
) (
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] lim_q,
  input  logic [CW-1:0] free_a,
  input  logic [CW-1:0] pend_a,
  output logic [CW-1:0] lim_n,
  output logic [CW-1:0] free_n,
  output logic [CW-1:0] pend_n
);
  localparam logic [CW-1:0] MAXC = CW'(MAX_TOKENS);

  logic [CW-1:0] want;
  logic [CW-1:0] delta;
  logic [CW-1:0] part;
  lim_act_e      act;

  always_comb begin
    want = (wdata > MAXC) ? MAXC : wdata;
    if (!wr)             act = LIM_KEEP;
    else if (want > lim_q) act = LIM_RAISE;
    else if (want < lim_q) act = LIM_LOWER;
    else                 act = LIM_KEEP;

    delta  = '0;
    part   = '0;
    lim_n  = lim_q;
    free_n = free_a;
    pend_n = pend_a;
    case (act)
      LIM_RAISE: begin
        delta  = want - lim_q;
        part   = (delta < pend_a) ? delta : pend_a;
        pend_n = pend_a - part;
        free_n = free_a + (delta - part);
        lim_n  = want;
      end
      LIM_LOWER: begin
        delta  = lim_q - want;
        part   = (delta < free_a) ? delta : free_a;
        free_n = free_a - part;
        pend_n = pend_a + (delta - part);
        lim_n  = want;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tok_throttle.sv
module tok_throttle
  import tok_pkg::*;
#(
  parameter int MAX_TOKENS  = 8,
  parameter int RESET_LIMIT = MAX_TOKENS,
  parameter int CW          = $clog2(MAX_TOKENS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  output logic          fetch_gnt,
  input  logic [CW-1:0] retire_cnt,
  input  logic [CW-1:0] flush_cnt,
  input  logic          limit_wr,
  input  logic [CW-1:0] limit_wdata,
  input  logic [CW-1:0] lowspec_thr,
  output logic [CW-1:0] tok_free,
  output logic [CW-1:0] tok_inflight,
  output logic [CW-1:0] tok_pending,
  output logic [CW-1:0] tok_limit,
  output logic          low_spec,
  output logic          pred_en
);
  localparam int SW = CW + 1;
  localparam logic [CW-1:0] RST_LIM = CW'(RESET_LIMIT);

  logic [RST_SYNC_STAGES-1:0] sync_q;
  logic                       run;

  logic [CW-1:0] free_q, infl_q, pend_q, lim_q;
  logic [CW-1:0] free_a, pend_a, infl_n;
  logic [CW-1:0] free_n, pend_n, lim_n;
  logic [SW-1:0] back;
  logic [CW-1:0] swallow;
  logic          gnt;
  logic          upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign run = sync_q[RST_SYNC_STAGES-1];

  tok_grant #(.CW(CW)) u_grant (
    .run    (run),
    .req    (fetch_req),
    .free_q (free_q),
    .gnt    (gnt)
  );

  tok_return #(.CW(CW), .SW(SW)) u_ret (
    .retire_cnt (retire_cnt),
    .flush_cnt  (flush_cnt),
    .pend_q     (pend_q),
    .back       (back),
    .swallow    (swallow)
  );

  always_comb begin
    free_a = CW'(SW'(free_q) + back - SW'(swallow) - SW'(gnt));
    pend_a = pend_q - swallow;
    infl_n = CW'(SW'(infl_q) + SW'(gnt) - back);
    upd    = run & (gnt | (back != '0) | limit_wr);
  end

  tok_limit #(.MAX_TOKENS(MAX_TOKENS), .CW(CW)) u_lim (
    .wr     (limit_wr),
    .wdata  (limit_wdata),
    .lim_q  (lim_q),
    .free_a (free_a),
    .pend_a (pend_a),
    .lim_n  (lim_n),
    .free_n (free_n),
    .pend_n (pend_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= RST_LIM;
      infl_q <= '0;
      pend_q <= '0;
      lim_q  <= RST_LIM;
    end else if (upd) begin
      free_q <= free_n;
      infl_q <= infl_n;
      pend_q <= pend_n;
      lim_q  <= lim_n;
    end
  end

  always_comb begin
    fetch_gnt    = gnt;
    tok_free     = free_q;
    tok_inflight = infl_q;
    tok_pending  = pend_q;
    tok_limit    = lim_q;
    low_spec     = (lim_q <= lowspec_thr);
    pred_en      = ~low_spec;
  end
endmodule

// File: rtl/tok_throttle_chk.sv
module tok_throttle_chk #(
  parameter int MAX_TOKENS = 8,
  parameter int CW         = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic          fetch_gnt,
  input logic [CW-1:0] retire_cnt,
  input logic [CW-1:0] flush_cnt,
  input logic [CW-1:0] tok_free,
  input logic [CW-1:0] tok_inflight,
  input logic [CW-1:0] tok_pending,
  input logic [CW-1:0] tok_limit,
  input logic          low_spec,
  input logic          pred_en
);
  localparam int SW = CW + 2;

  assert_gnt_needs_token_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_gnt |-> (fetch_req && tok_free != '0));

  assert_conserve_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(tok_free) + SW'(tok_inflight)) == (SW'(tok_limit) + SW'(tok_pending)));

  assert_pend_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_pending <= tok_inflight);

  assert_inflight_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (SW'(tok_inflight) + SW'($past(retire_cnt)) + SW'($past(flush_cnt)))
             == (SW'($past(tok_inflight)) + SW'($past(fetch_gnt))));

  assert_limit_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tok_limit <= CW'(MAX_TOKENS));

  assert_pred_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pred_en != low_spec);
endmodule

bind tok_throttle tok_throttle_chk #(.MAX_TOKENS(MAX_TOKENS), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_req    (fetch_req),
  .fetch_gnt    (fetch_gnt),
  .retire_cnt   (retire_cnt),
  .flush_cnt    (flush_cnt),
  .tok_free     (tok_free),
  .tok_inflight (tok_inflight),
  .tok_pending  (tok_pending),
  .tok_limit    (tok_limit),
  .low_spec     (low_spec),
  .pred_en      (pred_en)
);

// File: tb/sim_tok_throttle.sv
module sim_tok_throttle;
  localparam int PERIOD = 10;
  localparam int MAXT   = 8;
  localparam int CW     = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_req;
  logic          fetch_gnt;
  logic [CW-1:0] retire_cnt, flush_cnt, limit_wdata, lowspec_thr;
  logic          limit_wr;
  logic [CW-1:0] tok_free, tok_inflight, tok_pending, tok_limit;
  logic          low_spec, pred_en;

  int checks = 0;
  int errors = 0;
  int m_free, m_infl, m_pend, m_lim;
  int last_g;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tok_throttle #(.MAX_TOKENS(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
    .retire_cnt(retire_cnt), .flush_cnt(flush_cnt), .limit_wr(limit_wr),
    .limit_wdata(limit_wdata), .lowspec_thr(lowspec_thr), .tok_free(tok_free),
    .tok_inflight(tok_inflight), .tok_pending(tok_pending), .tok_limit(tok_limit),
    .low_spec(low_spec), .pred_en(pred_en)
  );

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one clock cycle of stimulus with model update and output comparison
  task automatic step(bit req, int ret, int fl, bit wr, int wd);
    int r, sw, d, p, wc, g;
    fetch_req   = req;
    retire_cnt  = CW'(ret);
    flush_cnt   = CW'(fl);
    limit_wr    = wr;
    limit_wdata = CW'(wd);
    #1;
    g = (req && m_free > 0) ? 1 : 0;
    chk(int'(fetch_gnt) == g, "R1 grant", int'(fetch_gnt), g);
    r  = ret + fl;
    sw = imin(r, m_pend);
    m_pend = m_pend - sw;
    m_free = m_free - g + r - sw;
    m_infl = m_infl + g - r;
    if (wr) begin
      wc = imin(wd, MAXT);
      if (wc > m_lim) begin
        d = wc - m_lim; p = imin(d, m_pend);
        m_pend -= p; m_free += d - p;
      end else if (wc < m_lim) begin
        d = m_lim - wc; p = imin(d, m_free);
        m_free -= p; m_pend += d - p;
      end
      m_lim = wc;
    end
    last_g = g;
    @(posedge clk);
    #1;
    fetch_req = 0; retire_cnt = '0; flush_cnt = '0; limit_wr = 0;
    chk(int'(tok_free) == m_free, "R10 free", int'(tok_free), m_free);
    chk(int'(tok_inflight) == m_infl, "R10 inflight", int'(tok_inflight), m_infl);
    chk(int'(tok_pending) == m_pend, "R10 pending", int'(tok_pending), m_pend);
    chk(int'(tok_limit) == m_lim, "R8 limit", int'(tok_limit), m_lim);
    chk(int'(low_spec) == ((m_lim <= int'(lowspec_thr)) ? 1 : 0), "R9 low_spec",
        int'(low_spec), (m_lim <= int'(lowspec_thr)) ? 1 : 0);
    chk(pred_en == ~low_spec, "R9 pred_en", int'(pred_en), int'(~low_spec));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    int hist[0:7];
    int stalls, grants, lfsr;
    rst_n = 0; fetch_req = 0; retire_cnt = '0; flush_cnt = '0;
    limit_wr = 0; limit_wdata = '0; lowspec_thr = 4'd2;
    m_free = MAXT; m_lim = MAXT; m_infl = 0; m_pend = 0; last_g = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(tok_limit == CW'(MAXT), "R11 limit", int'(tok_limit), MAXT);
    chk(tok_free == CW'(MAXT), "R11 free", int'(tok_free), MAXT);
    chk(tok_inflight == '0 && tok_pending == '0, "R11 inflight/pending",
        int'(tok_inflight) + int'(tok_pending), 0);
    chk(fetch_gnt == 1'b0, "R11 gnt", int'(fetch_gnt), 0);

    // R1 R8 R3: saturate for every limit, then flush all at once
    for (int L = 0; L <= 10; L++) begin
      step(0, 0, 0, 1, L);
      grants = 0;
      for (int k = 0; k < 10; k++) begin
        step(1, 0, 0, 0, 0);
        grants += last_g;
      end
      chk(grants == imin(L, MAXT), "R1 grants to limit", grants, imin(L, MAXT));
      step(0, m_infl / 2, m_infl - m_infl / 2, 0, 0);
      chk(int'(tok_free) == imin(L, MAXT), "R3 flush+retire", int'(tok_free), imin(L, MAXT));
    end

    // R5: full speed with limit equal to depth
    for (int S = 2; S <= 6; S++) begin
      step(0, 0, 0, 1, S);
      for (int k = 0; k < 8; k++) hist[k] = 0;
      stalls = 0;
      for (int c = 0; c < 30; c++) begin
        step(1, hist[S-2], 0, 0, 0);
        if (last_g == 0) stalls++;
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = last_g;
      end
      chk(stalls == 0, "R5 no stall", stalls, 0);
      step(0, 0, m_infl, 0, 0);
    end

    // R6: lowering with all tokens in flight, then swallow on returns
    step(0, 0, 0, 1, 8);
    for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 3);
    chk(tok_pending == 4'd5 && tok_free == '0, "R6 pending after lower", int'(tok_pending), 5);
    step(0, 2, 0, 0, 0);
    chk(tok_free == '0 && tok_pending == 4'd3, "R6 swallow", int'(tok_pending), 3);
    step(0, 4, 0, 0, 0);
    chk(tok_free == 4'd1 && tok_pending == '0, "R6 swallow done", int'(tok_free), 1);
    // R2: plain retire with nothing pending
    step(0, 1, 0, 0, 0);
    chk(tok_free == 4'd2, "R2 retire", int'(tok_free), 2);
    // R6: lowering withdraws idle tokens first
    step(0, 0, 0, 1, 1);
    chk(tok_free == '0 && tok_pending == '0, "R6 idle withdraw", int'(tok_free), 0);
    // R7: raise cancels pending first
    step(0, 0, 0, 1, 0);
    chk(tok_pending == 4'd1, "R7 setup", int'(tok_pending), 1);
    step(0, 0, 0, 1, 5);
    chk(tok_pending == '0 && tok_free == 4'd4, "R7 raise", int'(tok_free), 4);
    // R4: grant and return in the same cycle
    step(1, 1, 0, 0, 0);
    chk(tok_inflight == 4'd1 && tok_free == 4'd4, "R4 same cycle", int'(tok_inflight), 1);
    step(0, 0, m_infl, 1, 8);

    // R9: threshold sweep
    for (int t = 0; t <= 8; t++) begin
      lowspec_thr = CW'(t);
      for (int L = 0; L <= 8; L += 2) begin
        step(0, 0, 0, 1, L);
        chk(int'(low_spec) == ((L <= t) ? 1 : 0), "R9 threshold", int'(low_spec), (L <= t) ? 1 : 0);
      end
    end
    lowspec_thr = 4'd2;

    // mixed traffic
    lfsr = 16'hACE1;
    for (int c = 0; c < 600; c++) begin
      int r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
      r = ((lfsr >> 4) & 15) % (m_infl + 1);
      if (((lfsr >> 8) & 3) != 0) r = imin(r, 1);
      step(lfsr[0], r - r / 3, r / 3, ((lfsr >> 9) & 7) == 0, (lfsr >> 12) & 15);
    end

    finish_run();
  end
endmodule